// File: doc/BRIEF.md
# UART Receive FIFO Controller

This block is the receive-side buffer of a 16550-style serial port. An upstream deserialiser hands it complete characters, one per strobe, and reports line breaks on a separate strobe. The block stores characters in a byte FIFO and gives them to the host one per read strobe. It keeps the data-ready, overrun and break status bits. It raises two interrupt requests: one when enough characters are waiting, and one when characters have sat unread for four character times.

The host controls it through a write to the FIFO control byte. Bit 0 enables FIFO mode, bit 1 flushes the receive queue, and bits 7:6 pick the interrupt threshold. The host also writes the length of one character time in clock ticks, sets the receive-interrupt enable, and pulses a status-read strobe to clear the overrun bit. With FIFO mode off, the queue works as a single holding register.

Top module: `uart_rxq_ctrl`

## Requirements
- R1: The queue holds up to 16 bytes and returns them in arrival order. `rxq_level` always reports how many bytes are stored.
- R2: A byte that arrives when there is no room is dropped, and the stored bytes are left as they were. The drop sets `st_overrun`, which stays set until a `st_read_clr` pulse.
- R3: A control write with bit 0 set loads the threshold from bits 7:6. Code 0 selects 1 byte, code 1 selects 4, code 2 selects 8 and code 3 selects 14.
- R4: In FIFO mode, `irq_data` is high only when `rx_irq_en` is high, data-ready is set and the level is at least the threshold. When `rx_irq_en` is low, neither request is raised.
- R5: A control write with bit 0 clear leaves FIFO mode. In that mode, a byte is accepted only when the queue is empty, and `irq_data` needs only `rx_irq_en` and data-ready.
- R6: A control write with bit 1 set empties the queue, clears data-ready and break, stops the idle timer and drops any pending timeout.
- R7: In FIFO mode, every incoming byte or break sets data-ready and restarts a timer of four character times. When the timer runs out while data is stored, a timeout becomes pending and `irq_timeout` rises (with `rx_irq_en` high).
- R8: A host read that removes the last byte clears data-ready and break. A read that leaves data behind restarts the timer in FIFO mode. Any read that removes a byte clears a pending timeout.
- R9: A break strobe pushes a 0x00 byte under the same room rule as R2, and sets both break and data-ready.
- R10: After reset, one character time is CLK_HZ*10/9600 ticks. A `char_ticks_we` pulse replaces it with `char_ticks_in`, where 0 counts as 1.
- R11: `irq_data` is never high while `irq_timeout` is high.
- R12: While the queue is empty, `rd_data` is 0x00, and a read strobe changes neither the level nor the status bits.
- R13: A byte that arrives in the same cycle as a read of a full queue is accepted, overrun is not set, and the level stays at 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One received character is on `rx_data` |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | Break condition detected |
| rd_en | input | 1 | Host reads the head byte |
| fcr_we | input | 1 | Control byte write |
| fcr_wdata | input | 8 | Control byte: bit0 FIFO mode, bit1 flush, bits7:6 threshold |
| st_read_clr | input | 1 | Status read, clears overrun |
| rx_irq_en | input | 1 | Receive interrupt enable |
| char_ticks_we | input | 1 | Load character time |
| char_ticks_in | input | 32 | Character time in clock ticks |
| rd_data | output | 8 | Head byte, 0x00 when empty |
| st_ready | output | 1 | Data-ready status |
| st_overrun | output | 1 | Overrun status |
| st_break | output | 1 | Break status |
| rxq_level | output | 5 | Stored byte count |
| irq_data | output | 1 | Data-available request |
| irq_timeout | output | 1 | Character-timeout request |

## Verification
The assertions assume that `rx_valid` and `rx_break` are never high in the same cycle, and that a flush does not come in the same cycle as a break. They also assume `rd_data` is only used while the read strobe is high or before it. The bench drives every strobe for exactly one cycle, keeps the two receive strobes apart, and starts every timeout measurement from a known push edge. It sets a short character time before the flood tests, so that the timer does not go off between pushes.

// File: rtl/uart_rxq_pkg.sv
// Package: shared types for the receive FIFO controller.
// Assumes thresholds are meaningful for a queue of at least 14 entries.
package uart_rxq_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE  = 2'd0,
        TRIG_FOUR = 2'd1,
        TRIG_EIGHT = 2'd2,
        TRIG_FOURTEEN = 2'd3
    } trig_sel_e;

    // Map a threshold code to a byte count.
    function automatic logic [4:0] trig_level(trig_sel_e sel);
        case (sel)
            TRIG_ONE:   return 5'd1;
            TRIG_FOUR:  return 5'd4;
            TRIG_EIGHT: return 5'd8;
            default:    return 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
// Module: byte queue with occupancy count.
// Drops a push when there is no room after any same-cycle pop.
// In single mode, a push is taken only if the queue is empty after the pop.
// Assumes DEPTH is a power of two.
module rxq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          single,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          popped,
    output logic          dropped,
    output logic          empty_next
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] after_pop, count_next;
    logic          room, accept;

    // Work out pop, room and acceptance for this cycle.
    always_comb begin
        popped     = pop && (count != '0) && !flush;
        after_pop  = count - CW'(popped);
        room       = single ? (after_pop == '0) : (after_pop < CW'(DEPTH));
        accept     = push && room && !flush;
        dropped    = push && !room && !flush;
        count_next = flush ? '0 : after_pop + CW'(accept);
        empty_next = (count_next == '0);
        head       = (count != '0) ? mem[rd_ptr] : '0;
    end

    // Store accepted bytes.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_data;
    end

    // Move the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            if (popped) rd_ptr <= rd_ptr + 1'b1;
            count <= count_next;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R1
    AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> $stable(count)); // R2

endmodule

// File: rtl/rxq_timer.sv
// Module: four-character idle timer.
// Counts ticks per character and four characters. When it runs out with data
// stored, a timeout becomes pending. Cancel wins over restart.
module rxq_timer #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          cancel,
    input  logic          clear_pend,
    input  logic          has_data,
    input  logic [TW-1:0] char_ticks,
    output logic          pend
);

    logic [TW-1:0] tick_cnt, limit;
    logic [1:0]    char_cnt;
    logic          armed, last_tick, expire;

    // Decode the end of a character and the end of the window.
    always_comb begin
        limit     = (char_ticks == '0) ? TW'(1) : char_ticks;
        last_tick = (tick_cnt == limit - 1'b1);
        expire    = armed && (char_cnt == 2'd3) && last_tick;
    end

    // Run the tick and character counters.
    always_ff @(posedge clk) begin
        if (!rst_n || cancel) begin
            armed    <= 1'b0;
            tick_cnt <= '0;
            char_cnt <= '0;
        end else if (restart) begin
            armed    <= 1'b1;
            tick_cnt <= '0;
            char_cnt <= '0;
        end else if (armed) begin
            if (last_tick) begin
                tick_cnt <= '0;
                char_cnt <= char_cnt + 1'b1;
                if (expire) armed <= 1'b0;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // Hold the pending timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n || cancel || clear_pend) pend <= 1'b0;
        else if (expire && has_data)        pend <= 1'b1;
    end

    AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(has_data)); // R7
    AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !pend); // R6

endmodule

// File: rtl/rxq_status.sv
// Module: line status bits and the two interrupt requests.
// The timeout request outranks the data-available request.
module rxq_status #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          rx_evt,
    input  logic          brk_evt,
    input  logic          dropped,
    input  logic          read_empties,
    input  logic          oe_clr,
    input  logic          fifo_mode,
    input  logic          irq_en,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] threshold,
    input  logic          tmo_pend,
    output logic          dr,
    output logic          bi,
    output logic          oe,
    output logic          irq_data,
    output logic          irq_tmo
);

    // Keep data-ready and break.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            dr <= 1'b0;
            bi <= 1'b0;
        end else begin
            if (rx_evt)            dr <= 1'b1;
            else if (read_empties) dr <= 1'b0;
            if (brk_evt)           bi <= 1'b1;
            else if (read_empties) bi <= 1'b0;
        end
    end

    // Keep overrun; a new drop wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       oe <= 1'b0;
        else if (dropped) oe <= 1'b1;
        else if (oe_clr)  oe <= 1'b0;
    end

    // Form the requests with the timeout first.
    always_comb begin
        irq_tmo  = irq_en && tmo_pend;
        irq_data = irq_en && dr && (!fifo_mode || level >= threshold) && !irq_tmo;
    end

    AST_OE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> oe); // R2
    AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_evt && !flush) |=> (bi && dr)); // R9

endmodule

// File: rtl/uart_rxq_ctrl.sv
// Module: top of the receive FIFO controller.
// Holds the control state (mode, threshold, character time) and wires the
// queue, the idle timer and the status logic together.
// Assumes rx_valid and rx_break are never high together.
module uart_rxq_ctrl
    import uart_rxq_pkg::*;
#(
    parameter int DW     = 8,
    parameter int DEPTH  = 16,
    parameter int TW     = 32,
    parameter int CLK_HZ = 100_000_000,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam longint CT_RST = (longint'(CLK_HZ) * 10) / 9600
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_break,
    input  logic          rd_en,
    input  logic          fcr_we,
    input  logic [7:0]    fcr_wdata,
    input  logic          st_read_clr,
    input  logic          rx_irq_en,
    input  logic          char_ticks_we,
    input  logic [TW-1:0] char_ticks_in,
    output logic [DW-1:0] rd_data,
    output logic          st_ready,
    output logic          st_overrun,
    output logic          st_break,
    output logic [CW-1:0] rxq_level,
    output logic          irq_data,
    output logic          irq_timeout
);

    logic          fifo_mode;
    trig_sel_e     trig_sel;
    logic [TW-1:0] char_ticks;
    logic          flush, push, popped, dropped, empty_next;
    logic          restart, tmo_pend;
    logic [DW-1:0] push_data;

    // Decode strobes that drive the queue and the timer.
    always_comb begin
        flush     = fcr_we && fcr_wdata[1];
        push      = rx_valid || rx_break;
        push_data = rx_break ? '0 : rx_data;
        restart   = fifo_mode && ((push && !flush) || (popped && !empty_next));
    end

    // Hold the control byte fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_mode <= 1'b0;
            trig_sel  <= TRIG_ONE;
        end else if (fcr_we) begin
            fifo_mode <= fcr_wdata[0];
            if (fcr_wdata[0]) trig_sel <= trig_sel_e'(fcr_wdata[7:6]);
        end
    end

    // Hold the character time in clock ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)             char_ticks <= TW'(CT_RST);
        else if (char_ticks_we) char_ticks <= char_ticks_in;
    end

    rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .single(!fifo_mode),
        .push(push), .push_data(push_data), .pop(rd_en),
        .head(rd_data), .count(rxq_level), .popped(popped),
        .dropped(dropped), .empty_next(empty_next)
    );

    rxq_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .cancel(flush),
        .clear_pend(popped), .has_data(rxq_level != '0),
        .char_ticks(char_ticks), .pend(tmo_pend)
    );

    rxq_status #(.CW(CW)) u_status (
        .clk(clk), .rst_n(rst_n), .flush(flush), .rx_evt(push),
        .brk_evt(rx_break), .dropped(dropped),
        .read_empties(popped && empty_next), .oe_clr(st_read_clr),
        .fifo_mode(fifo_mode), .irq_en(rx_irq_en), .level(rxq_level),
        .threshold(CW'(trig_level(trig_sel))), .tmo_pend(tmo_pend),
        .dr(st_ready), .bi(st_break), .oe(st_overrun),
        .irq_data(irq_data), .irq_tmo(irq_timeout)
    );

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rxq_level == '0 && !irq_timeout && !st_ready)); // R6
    AST_READY_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rxq_level != '0) |-> st_ready); // R8
    AST_TMO_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_timeout |-> !irq_data); // R11
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && rxq_level == CW'(DEPTH) && rd_en && rx_valid && !fcr_we)
        |=> (rxq_level == CW'(DEPTH) && !$rose(st_overrun))); // R13

endmodule

// File: tb/uart_rxq_ctrl_tb.sv
module uart_rxq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 0, rx_break = 0, rd_en = 0, fcr_we = 0;
    logic        st_read_clr = 0, rx_irq_en = 0, char_ticks_we = 0;
    logic [7:0]  rx_data = 0, fcr_wdata = 0;
    logic [31:0] char_ticks_in = 0;
    logic [7:0]  rd_data;
    logic        st_ready, st_overrun, st_break, irq_data, irq_timeout;
    logic [4:0]  rxq_level;
    int          errors = 0, checks = 0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    uart_rxq_ctrl #(.CLK_HZ(96000)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .rd_en(rd_en), .fcr_we(fcr_we),
        .fcr_wdata(fcr_wdata), .st_read_clr(st_read_clr),
        .rx_irq_en(rx_irq_en), .char_ticks_we(char_ticks_we),
        .char_ticks_in(char_ticks_in), .rd_data(rd_data),
        .st_ready(st_ready), .st_overrun(st_overrun), .st_break(st_break),
        .rxq_level(rxq_level), .irq_data(irq_data), .irq_timeout(irq_timeout)
    );

    // Rows: {op(1 push, 2 pop), data, level after, irq_data after}
    localparam logic [15:0] VEC [18] = '{
        {2'd1, 8'h10, 5'd1,  1'b0}, {2'd1, 8'h11, 5'd2,  1'b0},
        {2'd1, 8'h12, 5'd3,  1'b0}, {2'd1, 8'h13, 5'd4,  1'b0},
        {2'd1, 8'h14, 5'd5,  1'b0}, {2'd1, 8'h15, 5'd6,  1'b0},
        {2'd1, 8'h16, 5'd7,  1'b0}, {2'd1, 8'h17, 5'd8,  1'b0},
        {2'd1, 8'h18, 5'd9,  1'b0}, {2'd1, 8'h19, 5'd10, 1'b0},
        {2'd1, 8'h1A, 5'd11, 1'b0}, {2'd1, 8'h1B, 5'd12, 1'b0},
        {2'd1, 8'h1C, 5'd13, 1'b0}, {2'd1, 8'h1D, 5'd14, 1'b1},
        {2'd1, 8'h1E, 5'd15, 1'b1}, {2'd1, 8'h1F, 5'd16, 1'b1},
        {2'd1, 8'hEE, 5'd16, 1'b1}, {2'd2, 8'h10, 5'd15, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); rx_valid = 1; rx_data = d;
        @(negedge clk); rx_valid = 0;
    endtask

    task automatic pop();
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic fcr(input logic [7:0] v);
        @(negedge clk); fcr_we = 1; fcr_wdata = v;
        @(negedge clk); fcr_we = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // Reset state and empty read
        chk("R12 reset level", rxq_level, 0);
        chk("R12 reset status", {st_ready, st_overrun, st_break}, 0);
        chk("R12 empty rd_data", rd_data, 8'h00);
        pop();
        chk("R12 empty read level", rxq_level, 0);
        chk("R12 empty read ready", st_ready, 0);

        // Default character time: 100 ticks, timeout after 400 edges
        rx_irq_en = 1;
        fcr(8'h01);
        push(8'hA5);
        chk("R4 threshold 1 request", irq_data, 1);
        idle(398);
        chk("R10 default time not yet", irq_timeout, 0);
        idle(3);
        chk("R7 timeout pending", irq_timeout, 1);
        chk("R11 data request masked", irq_data, 0);
        chk("R8 head byte", rd_data, 8'hA5);
        pop();
        chk("R8 ready cleared", st_ready, 0);
        chk("R8 pending cleared", irq_timeout, 0);

        // Short character time, threshold 14, table walk
        @(negedge clk); char_ticks_we = 1; char_ticks_in = 4;
        @(negedge clk); char_ticks_we = 0;
        fcr(8'hC1);
        for (int i = 0; i < 18; i++) begin
            if (VEC[i][15:14] == 2'd1) push(VEC[i][13:6]);
            else begin
                chk("R1 table head", rd_data, VEC[i][13:6]);
                pop();
            end
            chk("R1 table level", rxq_level, VEC[i][5:1]);
            chk("R3 table request", irq_data, VEC[i][0]);
        end
        chk("R2 overrun set", st_overrun, 1);
        push(8'h20);
        @(negedge clk); st_read_clr = 1;
        @(negedge clk); st_read_clr = 0;
        chk("R2 overrun cleared", st_overrun, 0);
        @(negedge clk); rd_en = 1; rx_valid = 1; rx_data = 8'h21;
        @(negedge clk); rd_en = 0; rx_valid = 0;
        chk("R13 level stays full", rxq_level, 16);
        chk("R13 no overrun", st_overrun, 0);
        for (int i = 0; i < 16; i++) begin
            chk("R1 drain order", rd_data, (i < 14) ? 8'h12 + i : 8'h20 + i - 14);
            pop();
        end
        chk("R8 drained ready", st_ready, 0);

        // Thresholds 4 and 8
        fcr(8'h41);
        push(1); push(2); push(3);
        chk("R3 four not met", irq_data, 0);
        push(4);
        chk("R3 four met", irq_data, 1);
        fcr(8'h81);
        chk("R3 eight not met", irq_data, 0);
        fcr(8'h83);
        chk("R6 flush level", rxq_level, 0);
        chk("R6 flush ready", st_ready, 0);

        // Flush cancels a running timer and a pending timeout
        push(8'h33);
        idle(10);
        fcr(8'h83);
        idle(30);
        chk("R6 cancelled timer", irq_timeout, 0);
        push(8'h34);
        idle(20);
        chk("R7 short timeout", irq_timeout, 1);
        fcr(8'h83);
        chk("R6 pending dropped", irq_timeout, 0);

        // Break
        @(negedge clk); rx_break = 1;
        @(negedge clk); rx_break = 0;
        chk("R9 break flags", {st_break, st_ready}, 2'b11);
        chk("R9 zero byte", rd_data, 8'h00);
        chk("R9 break level", rxq_level, 1);
        pop();
        chk("R8 break cleared", {st_break, st_ready}, 2'b00);

        // FIFO mode off
        fcr(8'h00);
        push(8'h55);
        chk("R5 request on ready", irq_data, 1);
        push(8'h66);
        chk("R5 single level", rxq_level, 1);
        chk("R5 second dropped", st_overrun, 1);
        rx_irq_en = 0;
        idle(1);
        chk("R4 disabled request", irq_data, 0);
        chk("R5 kept byte", rd_data, 8'h55);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule